// File: doc/BRIEF.md
# Memory Protection Region Checker

The checker sits next to a processor bus and judges every access in the same cycle that the access is presented. It holds a table of eight programmable regions. Each region has an enable, an aligned base address, a power-of-two size, a permission code, an execute-never bit, a memory type and a shareable bit. For each access, the checker reports whether the access is allowed. It also returns the attributes that apply to the access and the number of the region that decided it. Instruction fetches and data accesses use the same table.

Where regions overlap, the highest-numbered enabled region that contains the address decides. When no region contains the address, a fallback map applies: it grants every privileged access and refuses every unprivileged one. A global enable turns off checking completely.

A denied access sets a fault indication. This indication is registered on the next clock edge, together with the faulting address and the deciding region. It stays set until software clears it through the configuration write port.

Top module: `region_guard`

## Requirements
- R1: A region matches when its enable bit is set and the address bits at and above bit `size_lg` equal the matching bits of its base. Lower base bits are ignored. A written size code below 5 is stored as 5, and a code above the address width is stored as the address width, which makes the region span the whole address space.
- R2: When several enabled regions contain the address, `acc_region` and all attributes come from the region with the highest number.
- R3: When checking is on and no region matches, the fallback map applies. `acc_hit` is 0 and `acc_region` is 0. Privileged accesses are allowed and unprivileged accesses are refused. The attributes are type Normal, not shared and not execute-never.
- R4: Permission codes are applied to reads and writes as follows. Code 0 allows no access. Code 1 allows privileged read and write only. Code 2 allows privileged read and write, and unprivileged read. Code 3 allows read and write for everyone. Code 5 allows privileged read only. Code 6 allows read only for everyone. Codes 4 and 7 allow no access.
- R5: An instruction fetch is judged as a read, whatever `acc_write` is. A fetch that hits a region with execute-never set is refused, even when the region's permission code allows reads.
- R6: Memory type codes are 0 for Strongly-ordered, 1 for Device and 2 for Normal. A Strongly-ordered region always reports `acc_shared`=1. Any other type reports the region's shareable bit.
- R7: While the global enable is 0, every access is allowed. In that state `acc_hit` is 0, the attributes are Normal, non-shared and not execute-never, and no fault is recorded.
- R8: An access with `acc_valid`=1 that is refused sets `flt_valid` on the next edge and records the address, `acc_hit` and the region. Later faults do not overwrite a held record. A control write with bit 1 set clears `flt_valid` on that edge.
- R9: After reset, all regions are disabled, the global enable is 0 and `flt_valid` is 0. A region write applies to the access presented in the cycle right after the write edge. A disabled region never matches.

Configuration map. When `cfg_addr[4]`=1 the write goes to the control register: bit 0 is the global enable and bit 1 clears the fault record. When `cfg_addr[4]`=0, `cfg_addr[3:1]` selects the region and `cfg_addr[0]` selects the word. Word 0 is the base address. Word 1 holds the region attributes:

| Bit(s) | Field |
|---|---|
| [0] | enable |
| [6:1] | size_lg |
| [9:7] | permission |
| [10] | execute-never |
| [12:11] | type |
| [13] | shareable |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access is real (gates fault recording) |
| acc_addr | input | 32 | Access address |
| acc_priv | input | 1 | 1 = privileged access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_fetch | input | 1 | 1 = instruction fetch |
| acc_allow | output | 1 | Access permitted |
| acc_fault | output | 1 | acc_valid and refused |
| acc_hit | output | 1 | A region decided the access |
| acc_region | output | 3 | Deciding region number |
| acc_mtype | output | 2 | Memory type of the access |
| acc_shared | output | 1 | Shared attribute |
| acc_xn | output | 1 | Execute-never attribute |
| flt_valid | output | 1 | Fault record held |
| flt_addr | output | 32 | Recorded fault address |
| flt_hit | output | 1 | Recorded fault came from a region |
| flt_region | output | 3 | Recorded fault region |

## Verification
The priority rule is the hardest behaviour to reach, because it only shows when several regions contain the same address and their enables form every possible combination. The stimulus gives all eight regions nested spans that share address 0. It then steps the enable pattern through all 256 values and probes an address inside every span and an address inside only the larger spans. The expected winner is the highest enabled region that the bench computes for that address. Size boundaries come from a sweep of every size code: the bench probes the first and last byte of the span and the bytes just outside it.

// File: rtl/rg_pkg.sv
package rg_pkg;
  // memory type codes
  typedef enum logic [1:0] {
    MT_STRONG = 2'd0,
    MT_DEVICE = 2'd1,
    MT_NORMAL = 2'd2,
    MT_RSVD   = 2'd3
  } mtype_e;

  // attribute word layout
  localparam int AB_EN    = 0;
  localparam int AB_LG_LO = 1;
  localparam int LG_W     = 6;
  localparam int AB_AP_LO = 7;
  localparam int AP_W     = 3;
  localparam int AB_XN    = 10;
  localparam int AB_MT_LO = 11;
  localparam int AB_SH    = 13;

  typedef struct packed {
    logic              en;
    logic [LG_W-1:0]   lg;
    logic [AP_W-1:0]   ap;
    logic              xn;
    mtype_e            mt;
    logic              sh;
  } rattr_t;
endpackage

// File: rtl/rg_region_file.sv
module rg_region_file
  import rg_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int ADDR_W = 32,
  parameter int MIN_LG = 5,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic                   wr_word,
  input  logic [ADDR_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      look_addr,
  output logic [NREG-1:0]        hit_vec,
  output logic [NREG-1:0][AP_W-1:0] ap_o,
  output logic [NREG-1:0]        xn_o,
  output mtype_e [NREG-1:0]      mt_o,
  output logic [NREG-1:0]        sh_o
);
  logic [LG_W-1:0] lg_in, lg_clamped;

  always_comb begin
    lg_in = wr_data[AB_LG_LO +: LG_W];
    if (lg_in < LG_W'(MIN_LG))
      lg_clamped = LG_W'(MIN_LG);
    else if (lg_in > LG_W'(ADDR_W))
      lg_clamped = LG_W'(ADDR_W);
    else
      lg_clamped = lg_in;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    rattr_t            attr;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] mask;
    logic              sel;

    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        attr <= '{en: 1'b0, lg: LG_W'(MIN_LG), ap: '0, xn: 1'b0, mt: MT_STRONG, sh: 1'b0};
        base <= '0;
      end else if (sel) begin
        if (wr_word) begin
          attr.en <= wr_data[AB_EN];
          attr.lg <= lg_clamped;
          attr.ap <= wr_data[AB_AP_LO +: AP_W];
          attr.xn <= wr_data[AB_XN];
          attr.mt <= mtype_e'(wr_data[AB_MT_LO +: 2]);
          attr.sh <= wr_data[AB_SH];
        end else begin
          base <= wr_data;
        end
      end
    end

    always_comb begin
      if (int'(attr.lg) >= ADDR_W)
        mask = '0;
      else
        mask = {ADDR_W{1'b1}} << attr.lg;
    end

    assign hit_vec[i] = attr.en && (((look_addr ^ base) & mask) == '0);
    assign ap_o[i]    = attr.ap;
    assign xn_o[i]    = attr.xn;
    assign mt_o[i]    = attr.mt;
    assign sh_o[i]    = attr.sh;
  end
endmodule

// File: rtl/rg_prio_pick.sv
module rg_prio_pick #(
  parameter int NREG = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  hit_vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit_vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rg_perm_eval.sv
module rg_perm_eval
  import rg_pkg::*;
(
  input  logic [AP_W-1:0] ap,
  input  logic            xn,
  input  logic            priv,
  input  logic            write,
  input  logic            fetch,
  output logic            ok
);
  logic is_read;
  logic ap_ok;

  assign is_read = fetch | ~write;

  always_comb begin
    unique case (ap)
      3'd1:    ap_ok = priv;
      3'd2:    ap_ok = priv | is_read;
      3'd3:    ap_ok = 1'b1;
      3'd5:    ap_ok = priv & is_read;
      3'd6:    ap_ok = is_read;
      default: ap_ok = 1'b0;
    endcase
  end

  assign ok = ap_ok & ~(fetch & xn);
endmodule

// File: rtl/region_guard.sv
module region_guard
  import rg_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int ADDR_W = 32,
  parameter int MIN_LG = 5,
  localparam int IDX_W  = $clog2(NREG),
  localparam int CFG_AW = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_priv,
  input  logic              acc_write,
  input  logic              acc_fetch,
  output logic              acc_allow,
  output logic              acc_fault,
  output logic              acc_hit,
  output logic [IDX_W-1:0]  acc_region,
  output logic [1:0]        acc_mtype,
  output logic              acc_shared,
  output logic              acc_xn,
  output logic              flt_valid,
  output logic [ADDR_W-1:0] flt_addr,
  output logic              flt_hit,
  output logic [IDX_W-1:0]  flt_region
);
  logic                     ctl_wr, reg_wr, clr_req, glob_en;
  logic [NREG-1:0]          hit_vec;
  logic [NREG-1:0][AP_W-1:0] ap_v;
  logic [NREG-1:0]          xn_v, sh_v;
  mtype_e [NREG-1:0]        mt_v;
  logic                     any_hit, perm_ok;
  logic [IDX_W-1:0]         win_idx;
  mtype_e                   win_mt;

  assign ctl_wr  = cfg_we &  cfg_addr[CFG_AW-1];
  assign reg_wr  = cfg_we & ~cfg_addr[CFG_AW-1];
  assign clr_req = ctl_wr & cfg_wdata[1];

  always_ff @(posedge clk) begin
    if (rst)
      glob_en <= 1'b0;
    else if (ctl_wr)
      glob_en <= cfg_wdata[0];
  end

  rg_region_file #(.NREG(NREG), .ADDR_W(ADDR_W), .MIN_LG(MIN_LG)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .wr_idx    (cfg_addr[CFG_AW-2:1]),
    .wr_word   (cfg_addr[0]),
    .wr_data   (cfg_wdata),
    .look_addr (acc_addr),
    .hit_vec   (hit_vec),
    .ap_o      (ap_v),
    .xn_o      (xn_v),
    .mt_o      (mt_v),
    .sh_o      (sh_v)
  );

  rg_prio_pick #(.NREG(NREG)) u_pick (
    .hit_vec (hit_vec),
    .any     (any_hit),
    .idx     (win_idx)
  );

  rg_perm_eval u_perm (
    .ap    (ap_v[win_idx]),
    .xn    (xn_v[win_idx]),
    .priv  (acc_priv),
    .write (acc_write),
    .fetch (acc_fetch),
    .ok    (perm_ok)
  );

  assign win_mt = mt_v[win_idx];

  always_comb begin
    acc_allow  = 1'b1;
    acc_hit    = 1'b0;
    acc_region = '0;
    acc_mtype  = MT_NORMAL;
    acc_shared = 1'b0;
    acc_xn     = 1'b0;
    if (glob_en) begin
      if (any_hit) begin
        acc_allow  = perm_ok;
        acc_hit    = 1'b1;
        acc_region = win_idx;
        acc_mtype  = win_mt;
        acc_shared = (win_mt == MT_STRONG) | sh_v[win_idx];
        acc_xn     = xn_v[win_idx];
      end else begin
        acc_allow  = acc_priv;
      end
    end
  end

  assign acc_fault = acc_valid & ~acc_allow;

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_valid  <= 1'b0;
      flt_addr   <= '0;
      flt_hit    <= 1'b0;
      flt_region <= '0;
    end else begin
      if (clr_req)
        flt_valid <= 1'b0;
      if (acc_fault && (!flt_valid || clr_req)) begin
        flt_valid  <= 1'b1;
        flt_addr   <= acc_addr;
        flt_hit    <= acc_hit;
        flt_region <= acc_region;
      end
    end
  end
endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_req,
  input logic              glob_en,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_priv,
  input logic              acc_fetch,
  input logic              acc_allow,
  input logic              acc_hit,
  input logic              acc_xn,
  input logic [1:0]        acc_mtype,
  input logic              acc_shared,
  input logic              flt_valid,
  input logic [ADDR_W-1:0] flt_addr
);
  AST_BG_USER_DENY: assert property (@(posedge clk) disable iff (rst)
    (glob_en && !acc_hit && !acc_priv) |-> !acc_allow); // R3

  AST_XN_FETCH_DENY: assert property (@(posedge clk) disable iff (rst)
    (acc_fetch && acc_hit && acc_xn) |-> !acc_allow); // R5

  AST_STRONG_SHARED: assert property (@(posedge clk) disable iff (rst)
    (acc_mtype == 2'd0) |-> acc_shared); // R6

  AST_BYPASS_ALLOW: assert property (@(posedge clk) disable iff (rst)
    !glob_en |-> (acc_allow && !acc_hit)); // R7

  AST_FLT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_allow && !flt_valid) |=> (flt_valid && flt_addr == $past(acc_addr))); // R8

  AST_FLT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && !clr_req) |=> (flt_valid && flt_addr == $past(flt_addr))); // R8

  AST_FLT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !(acc_valid && !acc_allow)) |=> !flt_valid); // R8
endmodule

bind region_guard region_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_req    (clr_req),
  .glob_en    (glob_en),
  .acc_valid  (acc_valid),
  .acc_addr   (acc_addr),
  .acc_priv   (acc_priv),
  .acc_fetch  (acc_fetch),
  .acc_allow  (acc_allow),
  .acc_hit    (acc_hit),
  .acc_xn     (acc_xn),
  .acc_mtype  (acc_mtype),
  .acc_shared (acc_shared),
  .flt_valid  (flt_valid),
  .flt_addr   (flt_addr)
);

// File: tb/sim_region_guard.sv
`timescale 1ns/1ps
module sim_region_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_priv = 1'b0, acc_write = 1'b0, acc_fetch = 1'b0;
  logic        acc_allow, acc_fault, acc_hit, acc_shared, acc_xn;
  logic [2:0]  acc_region;
  logic [1:0]  acc_mtype;
  logic        flt_valid, flt_hit;
  logic [31:0] flt_addr;
  logic [2:0]  flt_region;

  always #10 clk = ~clk;  // 50 MHz

  region_guard u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_priv(acc_priv),
    .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_allow(acc_allow),
    .acc_fault(acc_fault), .acc_hit(acc_hit), .acc_region(acc_region),
    .acc_mtype(acc_mtype), .acc_shared(acc_shared), .acc_xn(acc_xn),
    .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_hit(flt_hit), .flt_region(flt_region)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // shadow of the programmed state
  logic        s_en [8];
  logic [31:0] s_base [8];
  int          s_lg [8];
  logic [2:0]  s_ap [8];
  logic        s_xn [8];
  logic [1:0]  s_mt [8];
  logic        s_sh [8];
  logic        s_glob = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_region(input int i, input logic en, input logic [31:0] base, input int lg,
                            input logic [2:0] ap, input logic xn, input logic [1:0] mt, input logic sh);
    logic [5:0] lgf;
    lgf = lg[5:0];
    wr_cfg({1'b0, i[2:0], 1'b0}, base);
    wr_cfg({1'b0, i[2:0], 1'b1}, {18'b0, sh, mt, xn, ap, lgf, en});
    s_en[i] = en; s_base[i] = base; s_ap[i] = ap; s_xn[i] = xn; s_mt[i] = mt; s_sh[i] = sh;
    s_lg[i] = (lgf < 6'd5) ? 5 : (lgf > 6'd32) ? 32 : int'(lgf);  // R1 clamp
  endtask

  task automatic set_ctl(input logic en, input logic clr);
    wr_cfg(5'h10, {30'b0, clr, en});
    s_glob = en;
  endtask

  function automatic logic perm_ok(input logic [2:0] ap, input logic priv, input logic wr, input logic fetch);
    logic rd;
    rd = fetch | ~wr;
    case (ap)
      3'd1: return priv;
      3'd2: return priv | rd;
      3'd3: return 1'b1;
      3'd5: return priv & rd;
      3'd6: return rd;
      default: return 1'b0;
    endcase
  endfunction

  // expected {allow, hit, region, mtype, shared, xn}
  function automatic logic [8:0] model(input logic [31:0] a, input logic priv, input logic wr, input logic fetch);
    logic hit; int idx; logic al; logic [1:0] mt; logic sh, xn;
    hit = 0; idx = 0;
    for (int i = 0; i < 8; i++) begin
      logic m;
      m = (s_lg[i] >= 32) ? 1'b1 : (((a ^ s_base[i]) >> s_lg[i]) == 32'd0);
      if (s_en[i] && m) begin hit = 1; idx = i; end
    end
    if (!s_glob)   begin al = 1; hit = 0; idx = 0; mt = 2; sh = 0; xn = 0; end
    else if (hit)  begin
      al = perm_ok(s_ap[idx], priv, wr, fetch) & ~(fetch & s_xn[idx]);
      mt = s_mt[idx]; sh = (mt == 2'd0) ? 1'b1 : s_sh[idx]; xn = s_xn[idx];
    end else       begin al = priv; idx = 0; mt = 2; sh = 0; xn = 0; end
    return {al, hit, idx[2:0], mt, sh, xn};
  endfunction

  task automatic probe(input string req, input logic [31:0] a, input logic priv, input logic wr, input logic fetch);
    @(negedge clk);
    acc_addr = a; acc_priv = priv; acc_write = wr; acc_fetch = fetch;
    #2;
    check(req, {55'b0, acc_allow, acc_hit, acc_region, acc_mtype, acc_shared, acc_xn},
          {55'b0, model(a, priv, wr, fetch)});
  endtask

  task automatic valid_access(input logic [31:0] a, input logic priv);
    @(negedge clk);
    acc_addr = a; acc_priv = priv; acc_write = 0; acc_fetch = 0; acc_valid = 1;
    @(negedge clk);
    acc_valid = 0;
    #2;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      s_en[i] = 0; s_base[i] = 0; s_lg[i] = 5; s_ap[i] = 0; s_xn[i] = 0; s_mt[i] = 0; s_sh[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R9 reset state; R7 checking off after reset
    @(negedge clk);
    check("R9 reset flt_valid", {63'b0, flt_valid}, 64'd0);
    probe("R7 reset bypass", 32'h1234_5678, 0, 1, 0);
    probe("R7 reset bypass fetch", 32'h0, 0, 0, 1);

    // R3 fallback map with no regions
    set_ctl(1, 0);
    probe("R3 fallback priv", 32'h8000_0000, 1, 1, 0);
    probe("R3 fallback user", 32'h8000_0000, 0, 0, 0);
    probe("R3 fallback user fetch", 32'h10, 0, 0, 1);

    // R4 R5 permission and execute-never sweep
    for (int ap = 0; ap < 8; ap++)
      for (int xn = 0; xn < 2; xn++) begin
        set_region(0, 1, 32'h2000_0000, 12, ap[2:0], xn[0], 2'd2, 1'b0);
        for (int k = 0; k < 8; k++)
          probe((k[2]) ? "R5 fetch perm" : "R4 perm", 32'h2000_0ABC, k[0], k[1], k[2]);
      end
    set_region(0, 0, 32'h0, 5, 3'd0, 0, 2'd0, 0);

    // R2 R6 priority over all enable patterns with nested regions
    for (int m = 0; m < 256; m++) begin
      for (int i = 0; i < 8; i++)
        set_region(i, m[i], 32'h0, 8 + i, 3'd3, 1'b0, 2'(i % 3), i[0]);
      probe("R2 overlap inner", 32'h0000_0080, m[0], 1, 0);
      probe("R6 overlap outer", 32'h0000_1000, 0, 0, 0);
    end
    for (int i = 0; i < 8; i++) set_region(i, 0, 32'h0, 5, 3'd0, 0, 2'd0, 0);

    // R1 size boundaries for every size code, plus clamping
    for (int lg = 5; lg <= 32; lg++) begin
      logic [31:0] b;
      logic [63:0] span;
      span = 64'd1 << lg;
      b = (lg >= 32) ? 32'h0 : ((32'hC000_0000 >> lg) << lg);
      set_region(3, 1, b, lg, 3'd5, 0, 2'd1, 1);
      probe("R1 first byte", b, 0, 0, 0);
      probe("R1 last byte", b + span[31:0] - 32'd1, 1, 1, 0);
      probe("R1 past end", b + span[31:0], 1, 0, 0);
      probe("R1 before base", b - 32'd1, 1, 0, 0);
    end
    set_region(3, 1, 32'h5000_0000, 0, 3'd3, 0, 2'd0, 0);
    probe("R1 clamp low in", 32'h5000_001F, 0, 1, 0);
    probe("R1 clamp low out", 32'h5000_0020, 0, 1, 0);
    set_region(3, 1, 32'h5000_0000, 45, 3'd3, 0, 2'd0, 0);
    probe("R1 clamp high", 32'hFFFF_FFF0, 0, 1, 0);
    set_region(3, 0, 32'h0, 5, 3'd0, 0, 2'd0, 0);

    // R9 write effect on the very next access; disabled never matches
    set_region(2, 1, 32'h6000_0000, 16, 3'd0, 0, 2'd2, 0);
    probe("R9 first access after write", 32'h6000_0100, 1, 0, 0);
    check("R9 denied after write", {63'b0, acc_allow}, 64'd0);
    set_region(2, 0, 32'h6000_0000, 16, 3'd0, 0, 2'd2, 0);
    probe("R9 disabled no match", 32'h6000_0100, 1, 0, 0);
    check("R9 disabled hit", {63'b0, acc_hit}, 64'd0);

    // R8 fault capture, hold and clear
    set_region(5, 1, 32'h7000_0000, 12, 3'd0, 0, 2'd2, 0);
    valid_access(32'h9000_0040, 0);
    check("R8 capture valid", {63'b0, flt_valid}, 64'd1);
    check("R8 capture addr", {32'b0, flt_addr}, 64'h9000_0040);
    check("R8 capture hit", {63'b0, flt_hit}, 64'd0);
    valid_access(32'h7000_0010, 1);
    check("R8 hold addr", {32'b0, flt_addr}, 64'h9000_0040);
    set_ctl(1, 1);
    @(negedge clk);
    check("R8 cleared", {63'b0, flt_valid}, 64'd0);
    valid_access(32'h7000_0010, 1);
    check("R8 region capture", {60'b0, flt_hit, flt_region}, {60'b0, 1'b1, 3'd5});
    check("R8 second addr", {32'b0, flt_addr}, 64'h7000_0010);
    set_ctl(1, 1);

    // R7 bypass with faulting regions present
    set_ctl(0, 0);
    probe("R7 bypass region", 32'h7000_0010, 0, 1, 1);
    valid_access(32'h7000_0010, 0);
    check("R7 no fault recorded", {63'b0, flt_valid}, 64'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule